// File: doc/BRIEF.md
# Systolic Min-Priority Queue

This block keeps a bounded set of keys and hands back the smallest one on request. It is built as a linear chain of identical cells. Each cell stores one key, and the chain stays in ascending order from the head, so the head always holds the minimum. A host drives one port. On that port it either inserts a key or extracts the minimum. The operation is accepted at the head, and its effect then ripples down the chain one cell per clock. As a result, every operation costs the same two clocks at the host, however many keys are stored.

Each cell works through a three-input sorter that yields minimum, median and maximum. A cell keeps the median and sends the maximum on to the next cell. A negative-infinity placeholder (all zeros) always sits on one sorter input, so the minimum output is never used. Empty slots hold a positive-infinity marker (all ones). Because of this, an insert pushes the new key and every larger key downward, and an extract pulls the next cell's key upward while a marker fills in behind. The block accepts work only on every other clock. This alternating input and output rhythm keeps two operations in flight at least two cells apart, so no cell ever reads a neighbour that is still being rewritten.

Top module: `pq_systolic`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `ext_valid_o` is 0 and `op_ready_o` is 1.
- R2: `op_ready_o` alternates every clock after reset, so operations are taken only on every second clock.
- R3: An accepted extract returns the smallest key currently held. Successive extracts return keys in ascending order.
- R4: `ext_valid_o` is high for exactly the one clock after the edge that accepted an extract, and `ext_key_o` holds the returned key during that clock. Inserts never raise it.
- R5: At every clock where `op_ready_o` is 1, `empty_o` is 1 exactly when no key is held. The head storing all ones means empty.
- R6: `full_o` is 1 exactly when DEPTH keys are held. An insert while full is ignored, and no stored key is lost off the tail.
- R7: An extract while empty is ignored, and `ext_valid_o` stays 0.
- R8: An insert whose key is all zeros or all ones is ignored, because those codes are the two infinity markers.
- R9: `op_valid_i` has no effect during a clock where `op_ready_o` is 0.
- R10: Equal keys are kept as separate entries, and each one is returned by its own extract.
- R11: Operations issued at every ready slot, back to back, in any mix, give the same results as a sorted multiset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation request, sampled only when `op_ready_o` is 1 |
| op_insert_i | input | 1 | 1 = insert `op_key_i`, 0 = extract minimum |
| op_key_i | input | KEY_W | Key to insert |
| op_ready_o | output | 1 | High on the clocks where a request is taken |
| ext_valid_o | output | 1 | Extracted key present on `ext_key_o` |
| ext_key_o | output | KEY_W | Extracted minimum |
| empty_o | output | 1 | Head slot holds the positive-infinity marker |
| full_o | output | 1 | DEPTH keys stored |

## Verification
A wrong key in a deep cell stays hidden until extracts pull it up to the head. It then shows as an out-of-order or unexpected value on `ext_key_o`, at most DEPTH extracts later. A key dropped during a ripple shows as `empty_o` rising too early while the queue is drained. Errors in the head counter or in the ready rhythm show at the very next ready slot, through `full_o`, `empty_o` or a missing `ext_valid_o` pulse. For this reason, every permutation of a full queue and a long random mix are each drained completely against a model multiset.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Kind of work a token carries down the chain
  typedef enum logic {
    PQ_EXTRACT = 1'b0,
    PQ_INSERT  = 1'b1
  } pq_op_e;

endpackage

// File: rtl/pq_sort3.sv
module pq_sort3 #(
  parameter int KEY_W = 16
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  input  logic [KEY_W-1:0] c_i,
  output logic [KEY_W-1:0] lo_o,
  output logic [KEY_W-1:0] mid_o,
  output logic [KEY_W-1:0] hi_o
);

  logic [KEY_W-1:0] ab_lo, ab_hi;

  always_comb begin
    ab_lo = (a_i < b_i) ? a_i : b_i;
    ab_hi = (a_i < b_i) ? b_i : a_i;
    lo_o  = (c_i < ab_lo) ? c_i : ab_lo;
    hi_o  = (c_i > ab_hi) ? c_i : ab_hi;
    if (c_i < ab_lo)      mid_o = ab_lo;
    else if (c_i > ab_hi) mid_o = ab_hi;
    else                  mid_o = c_i;
  end

endmodule

// File: rtl/pq_cell.sv
module pq_cell
  import pq_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tok_vld_i,
  input  pq_op_e           tok_op_i,
  input  logic [KEY_W-1:0] tok_key_i,
  input  logic [KEY_W-1:0] below_key_i,
  output logic [KEY_W-1:0] key_o,
  output logic             tok_vld_o,
  output pq_op_e           tok_op_o,
  output logic [KEY_W-1:0] tok_key_o
);

  localparam logic [KEY_W-1:0] POS_INF = '1;
  localparam logic [KEY_W-1:0] NEG_INF = '0;

  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] in_b, in_c;
  logic [KEY_W-1:0] s_lo, s_mid, s_hi;
  logic             is_ins, fwd_vld;

  // Insert: sort(-inf, new, own) -> keep median, pass max down.
  // Extract: sort(-inf, +inf, below) -> median is the key pulled up.
  always_comb begin
    is_ins  = (tok_op_i == PQ_INSERT);
    in_b    = is_ins ? tok_key_i : POS_INF;
    in_c    = is_ins ? key_q     : below_key_i;
    fwd_vld = tok_vld_i && (is_ins ? (s_hi != POS_INF) : (below_key_i != POS_INF));
  end

  pq_sort3 #(.KEY_W(KEY_W)) u_sort (
    .a_i  (NEG_INF),
    .b_i  (in_b),
    .c_i  (in_c),
    .lo_o (s_lo),
    .mid_o(s_mid),
    .hi_o (s_hi)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      key_q     <= POS_INF;
      tok_vld_o <= 1'b0;
      tok_op_o  <= PQ_EXTRACT;
      tok_key_o <= POS_INF;
    end else begin
      tok_vld_o <= fwd_vld;
      tok_op_o  <= tok_op_i;
      tok_key_o <= s_hi;
      if (tok_vld_i) key_q <= s_mid;
    end
  end

  assign key_o = key_q;

  AST_SORT_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
    tok_vld_i |-> (s_lo <= s_mid) && (s_mid <= s_hi)); // R3
  AST_NO_NEG_STORED: assert property (@(posedge clk_i) disable iff (rst_i)
    key_q != NEG_INF); // R8
  AST_ORDER_WITH_BELOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (tok_vld_i && is_ins) |-> (key_q <= below_key_i) || (below_key_i == POS_INF) || (key_q == POS_INF)); // R11

endmodule

// File: rtl/pq_head.sv
module pq_head
  import pq_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             op_valid_i,
  input  logic             op_insert_i,
  input  logic [KEY_W-1:0] op_key_i,
  input  logic [KEY_W-1:0] head_key_i,
  output logic             ready_o,
  output logic             ext_valid_o,
  output logic [KEY_W-1:0] ext_key_o,
  output logic             full_o,
  output logic             tok_vld_o,
  output pq_op_e           tok_op_o,
  output logic [KEY_W-1:0] tok_key_o
);

  localparam int               CNT_W   = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [KEY_W-1:0] POS_INF = '1;
  localparam logic [KEY_W-1:0] NEG_INF = '0;

  logic             ready_q, ext_vld_q, full_q;
  logic [KEY_W-1:0] ext_key_q;
  logic [CNT_W-1:0] count_q, count_nxt;
  logic             take, key_ok, head_empty, ins_ok, ext_ok;

  always_comb begin
    take       = op_valid_i && ready_q;
    key_ok     = (op_key_i != POS_INF) && (op_key_i != NEG_INF);
    head_empty = (head_key_i == POS_INF);
    ins_ok     = take && op_insert_i && (count_q != CNT_MAX) && key_ok;
    ext_ok     = take && !op_insert_i && !head_empty;
    count_nxt  = count_q;
    if (ins_ok)      count_nxt = count_q + 1'b1;
    else if (ext_ok) count_nxt = count_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ready_q   <= 1'b1;
      ext_vld_q <= 1'b0;
      ext_key_q <= POS_INF;
      count_q   <= '0;
      full_q    <= 1'b0;
      tok_vld_o <= 1'b0;
      tok_op_o  <= PQ_EXTRACT;
      tok_key_o <= POS_INF;
    end else begin
      ready_q   <= !ready_q;
      ext_vld_q <= ext_ok;
      if (ext_ok) ext_key_q <= head_key_i;
      count_q   <= count_nxt;
      full_q    <= (count_nxt == CNT_MAX);
      tok_vld_o <= ins_ok || ext_ok;
      tok_op_o  <= op_insert_i ? PQ_INSERT : PQ_EXTRACT;
      tok_key_o <= op_key_i;
    end
  end

  assign ready_o     = ready_q;
  assign ext_valid_o = ext_vld_q;
  assign ext_key_o   = ext_key_q;
  assign full_o      = full_q;

  AST_READY_ALT: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_q |=> !ready_q); // R2
  AST_READY_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_q |=> ready_q); // R2
  AST_EXT_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_vld_q |=> !ext_vld_q); // R4
  AST_EXT_REAL: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_vld_q |-> (ext_key_q != POS_INF) && (ext_key_q != NEG_INF)); // R3
  AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    count_q <= CNT_MAX); // R6
  AST_EMPTY_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_q |-> (head_empty == (count_q == '0))); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (full_q && op_valid_i && op_insert_i) |=> (count_q == CNT_MAX)); // R6
  AST_IDLE_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_q |=> !ext_vld_q); // R9

endmodule

// File: rtl/pq_systolic.sv
module pq_systolic
  import pq_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             op_valid_i,
  input  logic             op_insert_i,
  input  logic [KEY_W-1:0] op_key_i,
  output logic             op_ready_o,
  output logic             ext_valid_o,
  output logic [KEY_W-1:0] ext_key_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam logic [KEY_W-1:0] POS_INF = '1;

  logic [KEY_W-1:0] cell_key [DEPTH+1];
  logic             tok_vld  [DEPTH+1];
  pq_op_e           tok_op   [DEPTH+1];
  logic [KEY_W-1:0] tok_key  [DEPTH+1];

  assign cell_key[DEPTH] = POS_INF;

  pq_head #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_head (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .op_valid_i (op_valid_i),
    .op_insert_i(op_insert_i),
    .op_key_i   (op_key_i),
    .head_key_i (cell_key[0]),
    .ready_o    (op_ready_o),
    .ext_valid_o(ext_valid_o),
    .ext_key_o  (ext_key_o),
    .full_o     (full_o),
    .tok_vld_o  (tok_vld[0]),
    .tok_op_o   (tok_op[0]),
    .tok_key_o  (tok_key[0])
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    pq_cell #(.KEY_W(KEY_W)) u_cell (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tok_vld_i  (tok_vld[i]),
      .tok_op_i   (tok_op[i]),
      .tok_key_i  (tok_key[i]),
      .below_key_i(cell_key[i+1]),
      .key_o      (cell_key[i]),
      .tok_vld_o  (tok_vld[i+1]),
      .tok_op_o   (tok_op[i+1]),
      .tok_key_o  (tok_key[i+1])
    );
  end

  assign empty_o = (cell_key[0] == POS_INF);

  AST_NO_TAIL_LOSS: assert property (@(posedge clk_i) disable iff (rst_i)
    !(tok_vld[DEPTH] && tok_op[DEPTH] == PQ_INSERT && tok_key[DEPTH] != POS_INF)); // R6
  AST_NO_TAIL_EXTRACT: assert property (@(posedge clk_i) disable iff (rst_i)
    !(tok_vld[DEPTH] && tok_op[DEPTH] == PQ_EXTRACT)); // R3
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
    op_ready_o |-> !(full_o && empty_o)); // R5

endmodule

// File: tb/pq_systolic_tb.sv
`timescale 1ns/1ps
module pq_systolic_tb;

  localparam int KEY_W = 8;
  localparam int DEPTH = 4;
  localparam int MAXK  = (1 << KEY_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_valid = 1'b0;
  logic             op_insert = 1'b0;
  logic [KEY_W-1:0] op_key = '0;
  logic             op_ready, ext_valid, empty, full;
  logic [KEY_W-1:0] ext_key;

  int n_chk = 0;
  int n_err = 0;
  int mq[$];

  always #2 clk = ~clk;

  pq_systolic #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_i(rst), .op_valid_i(op_valid), .op_insert_i(op_insert),
    .op_key_i(op_key), .op_ready_o(op_ready), .ext_valid_o(ext_valid),
    .ext_key_o(ext_key), .empty_o(empty), .full_o(full));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; issues one operation at the next ready slot.
  task automatic do_op(input bit ins, input int key, input string req);
    int mi;
    while (op_ready !== 1'b1) @(negedge clk);
    check(empty == (mq.size() == 0), "R5 empty", int'(empty), int'(mq.size() == 0));
    check(full == (mq.size() == DEPTH), "R6 full", int'(full), int'(mq.size() == DEPTH));
    op_valid = 1'b1; op_insert = ins; op_key = key[KEY_W-1:0];
    @(negedge clk);
    op_valid = 1'b0;
    if (ins) begin
      if (mq.size() < DEPTH && key != 0 && key != MAXK) mq.push_back(key);
      check(ext_valid == 1'b0, "R4 insert pulse", int'(ext_valid), 0);
    end else if (mq.size() == 0) begin
      check(ext_valid == 1'b0, "R7 empty extract", int'(ext_valid), 0);
    end else begin
      mi = 0;
      foreach (mq[j]) if (mq[j] < mq[mi]) mi = j;
      check(ext_valid == 1'b1, "R4 valid", int'(ext_valid), 1);
      check(int'(ext_key) == mq[mi], req, int'(ext_key), mq[mi]);
      mq.delete(mi);
    end
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) do_op(1'b0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit r;
    int a [4];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    check(full == 1'b0, "R1 full", int'(full), 0);
    check(ext_valid == 1'b0, "R1 ext_valid", int'(ext_valid), 0);
    check(op_ready == 1'b1, "R1 ready", int'(op_ready), 1);

    // R2 ready alternates
    r = op_ready;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(op_ready == !r, "R2 alternate", int'(op_ready), int'(!r));
      r = op_ready;
    end

    // R9 request on a not-ready clock is dropped
    while (op_ready !== 1'b0) @(negedge clk);
    op_valid = 1'b1; op_insert = 1'b1; op_key = 8'd9;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(empty == 1'b1, "R9 not-ready insert", int'(empty), 1);
    check(ext_valid == 1'b0, "R9 no pulse", int'(ext_valid), 0);

    // R3/R6/R7: every insertion order of four keys, overfill, drain, extra extract
    a = '{10, 20, 30, 40};
    for (int p0 = 0; p0 < 4; p0++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++)
          for (int p3 = 0; p3 < 4; p3++)
            if (p0 != p1 && p0 != p2 && p0 != p3 && p1 != p2 && p1 != p3 && p2 != p3) begin
              do_op(1'b1, a[p0], "R3");
              do_op(1'b1, a[p1], "R3");
              do_op(1'b1, a[p2], "R3");
              do_op(1'b1, a[p3], "R3");
              do_op(1'b1, 5, "R6");      // full: ignored, 10 must still come first
              drain("R3 ascending");
              do_op(1'b0, 0, "R7");
            end

    // R8 sentinel keys are dropped
    do_op(1'b1, 0, "R8");
    do_op(1'b1, MAXK, "R8");
    while (op_ready !== 1'b1) @(negedge clk);
    check(empty == 1'b1, "R8 sentinel dropped", int'(empty), 1);
    do_op(1'b0, 0, "R8");

    // R10 equal keys
    do_op(1'b1, 7, "R10"); do_op(1'b1, 7, "R10");
    do_op(1'b1, 7, "R10"); do_op(1'b1, 3, "R10");
    drain("R10 duplicates");

    // R11 back-to-back random mix including boundary keys 1 and MAXK-1
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom_range(1, 30));
      if ($urandom_range(0, 15) == 0) k = 1;
      if ($urandom_range(0, 15) == 0) k = MAXK - 1;
      do_op($urandom_range(0, 99) < 55, k, "R11 random");
    end
    drain("R11 drain");
    while (op_ready !== 1'b1) @(negedge clk);
    check(empty == 1'b1, "R11 final empty", int'(empty), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule